// File: doc/BRIEF.md
# Dual-Processor Status Mailbox

This block is a one-word mailbox that a host processor and a signal-processing core share. Either side can deposit a 16-bit word into the mailbox and either side can read it back. A 2-bit status word sits beside the mailbox, with one flag for each direction of traffic. A write by one side raises that side's flag. A status read by the other side lowers it. Each processor can therefore poll to learn whether its peer has posted something new since the last time it looked.

The host reaches the block through a small word-offset bus: two aliased offsets for the mailbox, one offset for the status word, and one offset that accepts writes and discards them. The DSP reaches the block through a register-port interface with a port select. One port is the mailbox. A second port is the status word, and it behaves as the status word only while the DSP is not in pointer mode. Read data on both sides is registered. It appears the cycle after the read strobe, shows the state from before that cycle's updates, and holds until the next read on that side.

Top module: `dual_status_mailbox`

## Requirements
- R1: A synchronous active-high reset clears the mailbox, the status word, `host_rdata` and `dsp_rdata` to zero.
- R2: A host read at offset 0 or 1 puts the mailbox value, as it was before that cycle's updates, on `host_rdata` in the following cycle. `host_rdata` holds its value in any cycle without a host read.
- R3: A host write at offset 0 or 1 loads `host_wdata` into the mailbox and sets status bit 1.
- R4: A host read at offset 2 returns the pre-update status word in `host_rdata[1:0]`, with zeros above it, and clears status bit 0.
- R5: A host write at offset 3 or at offsets 4 to 7 changes nothing. A host read at offset 3 or at offsets 4 to 7 returns zero and changes nothing.
- R6: A DSP access with `dsp_port` = 1 (mailbox port) works as follows. A write loads `dsp_wdata` into the mailbox and sets status bit 0. A read returns the pre-update mailbox on `dsp_rdata` in the following cycle. `dsp_rdata` holds its value in any cycle without a DSP read.
- R7: A DSP read with `dsp_port` = 0 (status port) and `dsp_ptr_mode` low returns the pre-update status word in `dsp_rdata[1:0]`, with zeros above it, and clears status bit 1.
- R8: A DSP write with `dsp_port` = 0 and `dsp_ptr_mode` low loads the status word from `dsp_wdata[1:0]`.
- R9: A DSP access to port 0 while `dsp_ptr_mode` is high, or to port 2 or 3, changes nothing. A DSP read of any of these returns zero.
- R10: When both sides act in the same cycle, the following rules apply. A DSP mailbox write overrides a host mailbox write. A DSP status load replaces the old status first, and the per-bit sets and clears are then applied to the result. A set overrides a clear of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HOST_AW (3) | Host word offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DW (16) | Host write data |
| host_rdata | output | DW (16) | Registered host read data |
| dsp_port | input | 2 | DSP port select: 0 status, 1 mailbox, 2 and 3 unused |
| dsp_ptr_mode | input | 1 | DSP pointer mode; when high, status port accesses are bypassed |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_wdata | input | DW (16) | DSP write data |
| dsp_rdata | output | DW (16) | Registered DSP read data |

## Verification
The bench pairs every host operation, covering read and write at each of the eight offsets and idle, with every DSP operation, covering read and write on each port in both pointer modes and idle. After each pair it reads the status word and the mailbox back through the ports. This catches a flag raised or cleared by the wrong side, which would show as a peer seeing stale or phantom traffic. It also catches a discarded offset that leaks into the state, and a pointer-mode access that still touches the status. Same-cycle collisions are part of the sweep. A design that let a clear win over a set would lose a notification. A design that let the host override a DSP mailbox write would return the wrong word. Each read is compared against the value from before that cycle's updates, so a design that returns already-cleared status fails.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STS_W   = 2;
  localparam int STS_D2H = 0;  // raised by a DSP mailbox write
  localparam int STS_H2D = 1;  // raised by a host mailbox write

  typedef enum logic [1:0] {
    DPORT_STS  = 2'd0,
    DPORT_MBX  = 2'd1,
    DPORT_RSV2 = 2'd2,
    DPORT_RSV3 = 2'd3
  } dsp_port_e;

  typedef enum logic [1:0] {
    RSRC_ZERO = 2'd0,
    RSRC_MBX  = 2'd1,
    RSRC_STS  = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic    rd;
    rd_src_e src;
    logic    mbx_wr;
    logic    sts_rd;
    logic    sts_wr;
  } acc_t;
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
  import mbx_pkg::*;
#(
  parameter int AW       = 3,
  parameter int OFS_MBXA = 0,
  parameter int OFS_MBXB = 1,
  parameter int OFS_STS  = 2
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output acc_t          acc
);
  logic hit_mbx, hit_sts;

  always_comb begin
    hit_mbx = (addr == AW'(OFS_MBXA)) || (addr == AW'(OFS_MBXB));
    hit_sts = (addr == AW'(OFS_STS));
    acc.rd     = rd;
    acc.src    = hit_mbx ? RSRC_MBX : (hit_sts ? RSRC_STS : RSRC_ZERO);
    acc.mbx_wr = wr && hit_mbx;
    acc.sts_rd = rd && hit_sts;
    acc.sts_wr = 1'b0;  // host cannot load the status word
  end
endmodule

// File: rtl/mbx_dsp_dec.sv
module mbx_dsp_dec
  import mbx_pkg::*;
(
  input  logic [1:0] port,
  input  logic       ptr_mode,
  input  logic       rd,
  input  logic       wr,
  output acc_t       acc
);
  dsp_port_e p;
  logic      hit_mbx, hit_sts;

  always_comb begin
    p       = dsp_port_e'(port);
    hit_mbx = (p == DPORT_MBX);
    hit_sts = (p == DPORT_STS) && !ptr_mode;
    acc.rd     = rd;
    acc.src    = hit_mbx ? RSRC_MBX : (hit_sts ? RSRC_STS : RSRC_ZERO);
    acc.mbx_wr = wr && hit_mbx;
    acc.sts_rd = rd && hit_sts;
    acc.sts_wr = wr && hit_sts;
  end
endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic base;
    assign base = load ? load_val[b] : q[b];
    always_ff @(posedge clk) begin
      if (rst)         q[b] <= 1'b0;
      else if (set[b]) q[b] <= 1'b1;       // set outranks clear
      else if (clr[b]) q[b] <= 1'b0;
      else             q[b] <= base;
    end
  end
endmodule

// File: rtl/dual_status_mailbox.sv
module dual_status_mailbox
  import mbx_pkg::*;
#(
  parameter int DW      = 16,
  parameter int HOST_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic [1:0]         dsp_port,
  input  logic               dsp_ptr_mode,
  input  logic               dsp_rd,
  input  logic               dsp_wr,
  input  logic [DW-1:0]      dsp_wdata,
  output logic [DW-1:0]      dsp_rdata
);
  acc_t             h_acc, d_acc;
  logic [DW-1:0]    mbx_q;
  logic [STS_W-1:0] sts_q, sts_set, sts_clr;
  logic [DW-1:0]    h_rd_val, d_rd_val;

  mbx_host_dec #(.AW(HOST_AW)) i_host_dec (
    .addr(host_addr), .rd(host_rd), .wr(host_wr), .acc(h_acc)
  );

  mbx_dsp_dec i_dsp_dec (
    .port(dsp_port), .ptr_mode(dsp_ptr_mode), .rd(dsp_rd), .wr(dsp_wr), .acc(d_acc)
  );

  always_comb begin
    sts_set = '0;
    sts_clr = '0;
    sts_set[STS_H2D] = h_acc.mbx_wr;
    sts_set[STS_D2H] = d_acc.mbx_wr;
    sts_clr[STS_D2H] = h_acc.sts_rd;
    sts_clr[STS_H2D] = d_acc.sts_rd;
  end

  mbx_status_reg #(.W(STS_W)) i_sts (
    .clk(clk), .rst(rst),
    .load(d_acc.sts_wr), .load_val(dsp_wdata[STS_W-1:0]),
    .set(sts_set), .clr(sts_clr), .q(sts_q)
  );

  // mailbox word: DSP write wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (rst)               mbx_q <= '0;
    else if (d_acc.mbx_wr) mbx_q <= dsp_wdata;
    else if (h_acc.mbx_wr) mbx_q <= host_wdata;
  end

  function automatic logic [DW-1:0] pick(rd_src_e s, logic [DW-1:0] m,
                                         logic [STS_W-1:0] st);
    case (s)
      RSRC_MBX: pick = m;
      RSRC_STS: pick = {{(DW-STS_W){1'b0}}, st};
      default:  pick = '0;
    endcase
  endfunction

  assign h_rd_val = pick(h_acc.src, mbx_q, sts_q);
  assign d_rd_val = pick(d_acc.src, mbx_q, sts_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      dsp_rdata  <= '0;
    end else begin
      if (h_acc.rd) host_rdata <= h_rd_val;
      if (d_acc.rd) dsp_rdata  <= d_rd_val;
    end
  end
endmodule

// File: rtl/dual_status_mailbox_chk.sv
module dual_status_mailbox_chk #(
  parameter int DW      = 16,
  parameter int HOST_AW = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_rd,
  input logic               host_wr,
  input logic [DW-1:0]      host_wdata,
  input logic [DW-1:0]      host_rdata,
  input logic [1:0]         dsp_port,
  input logic               dsp_ptr_mode,
  input logic               dsp_rd,
  input logic               dsp_wr,
  input logic [DW-1:0]      dsp_wdata,
  input logic [DW-1:0]      dsp_rdata,
  input logic [DW-1:0]      mbx_q,
  input logic [1:0]         sts_q
);
  logic h_mbx, h_sts, d_mbx, d_sts, d_idle, h_other;
  assign h_mbx   = host_addr < HOST_AW'(2);
  assign h_sts   = host_addr == HOST_AW'(2);
  assign h_other = host_addr > HOST_AW'(2);
  assign d_mbx   = dsp_port == 2'd1;
  assign d_sts   = dsp_port == 2'd0 && !dsp_ptr_mode;
  assign d_idle  = !dsp_rd && !dsp_wr;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (mbx_q == '0 && sts_q == 2'b00 && host_rdata == '0 && dsp_rdata == '0)); // R1

  AST_HOST_RD_MBX: assert property (@(posedge clk) disable iff (rst)
    host_rd && h_mbx |=> host_rdata == $past(mbx_q)); // R2

  AST_HOST_WR_SETS: assert property (@(posedge clk) disable iff (rst)
    host_wr && h_mbx |=> sts_q[1]); // R3

  AST_HOST_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
    host_wr && h_mbx && !(dsp_wr && d_mbx) |=> mbx_q == $past(host_wdata)); // R3

  AST_HOST_STS_CLR: assert property (@(posedge clk) disable iff (rst)
    host_rd && h_sts && !(dsp_wr && (d_mbx || d_sts)) |=> !sts_q[0]); // R4

  AST_HOST_OTHER_NOP: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) && h_other && d_idle |=> $stable(mbx_q) && $stable(sts_q)); // R5

  AST_DSP_WR_SETS: assert property (@(posedge clk) disable iff (rst)
    dsp_wr && d_mbx |=> sts_q[0] && mbx_q == $past(dsp_wdata)); // R6

  AST_DSP_RD_MBX: assert property (@(posedge clk) disable iff (rst)
    dsp_rd && d_mbx |=> dsp_rdata == $past(mbx_q)); // R6

  AST_DSP_STS_CLR: assert property (@(posedge clk) disable iff (rst)
    dsp_rd && d_sts && !dsp_wr && !(host_wr && h_mbx) |=> !sts_q[1]); // R7

  AST_DSP_BYPASS_NOP: assert property (@(posedge clk) disable iff (rst)
    !d_mbx && !d_sts && !host_rd && !host_wr |=> $stable(mbx_q) && $stable(sts_q)); // R9
endmodule

bind dual_status_mailbox dual_status_mailbox_chk #(.DW(DW), .HOST_AW(HOST_AW)) i_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .dsp_port(dsp_port),
  .dsp_ptr_mode(dsp_ptr_mode), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata),
  .dsp_rdata(dsp_rdata), .mbx_q(mbx_q), .sts_q(sts_q)
);

// File: tb/test_dual_status_mailbox.sv
module test_dual_status_mailbox;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] host_addr;
  logic          host_rd, host_wr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [1:0]    dsp_port;
  logic          dsp_ptr_mode, dsp_rd, dsp_wr;
  logic [DW-1:0] dsp_wdata, dsp_rdata;

  int n_checks = 0;
  int n_errors = 0;

  // bench model
  logic [DW-1:0] m_mbx, m_hrd, m_drd;
  logic [1:0]    m_sts;

  always #2 clk = ~clk;  // 250 MHz

  dual_status_mailbox #(.DW(DW), .HOST_AW(AW)) i_dual_status_mailbox (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dsp_port(dsp_port),
    .dsp_ptr_mode(dsp_ptr_mode), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; model advanced per requirements; outputs sampled at next negedge
  task automatic step(logic hrd, logic hwr, logic [AW-1:0] ha, logic [DW-1:0] hd,
                      logic drd, logic dwr, logic [1:0] dp, logic ptr, logic [DW-1:0] dd,
                      string htag, string dtag);
    logic hm, hs, dm, ds;
    logic [1:0] base, setv, clrv;
    host_rd = hrd; host_wr = hwr; host_addr = ha; host_wdata = hd;
    dsp_rd = drd; dsp_wr = dwr; dsp_port = dp; dsp_ptr_mode = ptr; dsp_wdata = dd;
    hm = (ha < 3'd2);
    hs = (ha == 3'd2);
    dm = (dp == 2'd1);
    ds = (dp == 2'd0) && !ptr;
    if (hrd) m_hrd = hm ? m_mbx : (hs ? {14'b0, m_sts} : '0);      // R2 R4 R5
    if (drd) m_drd = dm ? m_mbx : (ds ? {14'b0, m_sts} : '0);      // R6 R7 R9
    base = (dwr && ds) ? dd[1:0] : m_sts;                           // R8 R10
    setv = {hwr && hm, dwr && dm};                                  // R3 R6
    clrv = {drd && ds, hrd && hs};                                  // R4 R7
    m_sts = (base & ~clrv) | setv;                                  // R10
    if (dwr && dm) m_mbx = dd;
    else if (hwr && hm) m_mbx = hd;
    @(negedge clk);
    check(htag, host_rdata, m_hrd);
    check(dtag, dsp_rdata, m_drd);
    host_rd = 0; host_wr = 0; dsp_rd = 0; dsp_wr = 0;
  endtask

  // read state back: host status read plus DSP mailbox read
  task automatic observe(string tag);
    step(1, 0, 3'd2, '0, 1, 0, 2'd1, 0, '0, tag, tag);
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1; host_rd = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    dsp_rd = 0; dsp_wr = 0; dsp_port = '0; dsp_ptr_mode = 0; dsp_wdata = '0;
    m_mbx = '0; m_sts = '0; m_hrd = '0; m_drd = '0;
    repeat (3) @(negedge clk);
    check("R1", host_rdata, '0);
    check("R1", dsp_rdata, '0);
    rst = 0;
    observe("R1");
    step(1, 0, 3'd0, '0, 1, 0, 2'd0, 0, '0, "R1", "R1");

    // directed cases
    step(0, 1, 3'd1, 16'h1234, 0, 0, 2'd0, 0, '0, "R3", "R3");
    step(1, 0, 3'd0, '0, 1, 0, 2'd0, 0, '0, "R2", "R7");
    step(0, 0, 3'd0, '0, 0, 1, 2'd1, 0, 16'hBEEF, "R6", "R6");
    step(1, 0, 3'd2, '0, 0, 0, 2'd0, 0, '0, "R4", "R4");
    step(1, 0, 3'd2, '0, 0, 0, 2'd0, 0, '0, "R4", "R4");
    step(0, 0, 3'd0, '0, 0, 1, 2'd0, 0, 16'hFFF3, "R8", "R8");
    step(1, 0, 3'd2, '0, 0, 0, 2'd0, 0, '0, "R8", "R8");
    step(0, 1, 3'd0, 16'h0A0A, 0, 1, 2'd1, 0, 16'h5050, "R10", "R10");
    observe("R10");

    // sweep: host op x DSP op, each followed by a readback
    for (int h = 0; h < 17; h++) begin
      for (int d = 0; d < 17; d++) begin
        logic hrd_i, hwr_i, drd_i, dwr_i, ptr_i;
        logic [AW-1:0] ha_i;
        logic [1:0] dp_i;
        hrd_i = (h >= 1 && h <= 8);
        hwr_i = (h >= 9);
        ha_i  = hrd_i ? AW'(h - 1) : (hwr_i ? AW'(h - 9) : '0);
        drd_i = (d >= 1 && d <= 8);
        dwr_i = (d >= 9);
        dp_i  = (d >= 1) ? 2'((d - 1) % 4) : 2'd0;
        ptr_i = (d >= 1) ? (((d - 1) / 4) % 2 == 1) : 1'b0;
        step(hrd_i, hwr_i, ha_i, 16'hA000 + 16'(h * 37 + d * 3),
             drd_i, dwr_i, dp_i, ptr_i, 16'h5000 + 16'(d * 13 + h * 5),
             "R2 R3 R4 R5 R10", "R6 R7 R8 R9 R10");
        observe("R5 R9 R10");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule